// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Register Bank

This block holds the 32-bit configuration space of a DRAM controller. Software reaches it over a single-access-per-cycle, word-indexed bus. Writes take effect at the clock edge. Reads return their data on the cycle after the read strobe. Every register except the guard word at index 0 is write-protected until software stores a 32-bit unlock key into that guard word. Any other value written to the guard word locks the bank again.

Each write is shaped before it is stored. The configuration word keeps hardware-owned fields at fixed values: a version code, an aperture code, an init-done flag and a memory-size code taken from parameters. The PHY status word and the self-test control word always report an idealised PHY: never busy, PLL locked in the later variant, and self-test finished without failure. Indices past the implemented word count read as zero and ignore writes.

Top module: `mcfg_regbank`

## Requirements
- R1: After reset, the guard word reads 0, the configuration word (index 1) reads its fixed hardware value, and every other implemented word reads 0.
- R2: A write to index 0 stores 1 when the data is 32'hFC600309 and stores 0 for any other data. A read of index 0 returns that value, with bits 31:1 reading 0.
- R3: While the guard word holds 0, writes to any index other than 0 leave the stored words unchanged.
- R4: `waddr_i` is the byte offset divided by 4, over a 4 KiB window. Read data appears on `rdata_o` one cycle after a read strobe and holds until the next read.
- R5: A read at an index of `NUM_WORDS` or above returns 0. A write at such an index changes no stored word.
- R6: A write to the configuration word (index 1) stores the written data with the read-only bits replaced by fixed values. The read-only bits are 31:28, 19, 18:14, 6, 3:2 and 1:0. Bits 31:28 take 1 when `VARIANT`=0 and 3 when `VARIANT`=1. Bit 19 takes 1 only when `VARIANT`=0. Bits 3:2 take 3. Bits 18:14 and bit 6 take 0.
- R7: Bits 1:0 of the configuration word hold log2(`MEM_SIZE_MB`/`MIN_SIZE_MB`), where the ratio is one of 1, 2, 4 or 8. Any other ratio stops elaboration.
- R8: A write to the PHY status word (index 24, byte offset 0x60) stores bit 0 as 0. When `VARIANT`=1 it also stores bit 4 as 1. All other bits are stored as written.
- R9: A write to the self-test word (index 28, byte offset 0x70) stores bit 12 as 1 and bit 13 as 0. All other bits are stored as written.
- R10: While unlocked, every other implemented index stores all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access strobe, one access per cycle |
| we_i | input | 1 | 1 for a write, 0 for a read |
| waddr_i | input | 10 | Word index (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |

## Verification
A wrong lock state shows up in two ways. A read of index 0 returns the wrong value on the next cycle. A locked write that leaks into storage shows the next time that word is read, so the bench reads every word after each phase. A wrong shaping mask or wrong fixed value appears in the first read of the affected word after the write. A wrong reset value appears in the first read after reset. The bench sweeps all 1024 word indices in each phase, so out-of-range aliasing and index decode faults also appear within one sweep.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
  localparam int          DATA_W       = 32;
  localparam int          IDX_W        = 10;  // 4 KiB window / 4
  localparam logic [31:0] UNLOCK_KEY   = 32'hFC60_0309;
  localparam int          IDX_GUARD    = 0;
  localparam int          IDX_CONF     = 1;
  localparam int          IDX_PHY      = 24;
  localparam int          IDX_SELFTEST = 28;
  localparam logic [31:0] CONF_RO_MASK = 32'hF00F_C04F;
  localparam int          PHY_BUSY_BIT = 0;
  localparam int          PLL_LOCK_BIT = 4;
  localparam int          ST_DONE_BIT  = 12;
  localparam int          ST_FAIL_BIT  = 13;

  function automatic logic [1:0] size_code(int mem_mb, int min_mb);
    if (mem_mb == min_mb * 8) return 2'd3;
    if (mem_mb == min_mb * 4) return 2'd2;
    if (mem_mb == min_mb * 2) return 2'd1;
    return 2'd0;
  endfunction

  function automatic bit size_ok(int mem_mb, int min_mb);
    return (min_mb > 0) && (mem_mb == min_mb || mem_mb == min_mb * 2 ||
                            mem_mb == min_mb * 4 || mem_mb == min_mb * 8);
  endfunction

  function automatic logic [31:0] conf_fixed(int variant, int mem_mb, int min_mb);
    logic [31:0] v;
    v          = '0;
    v[31:28]   = (variant != 0) ? 4'd3 : 4'd1;
    v[19]      = (variant == 0);
    v[3:2]     = 2'd3;
    v[1:0]     = size_code(mem_mb, min_mb);
    return v;
  endfunction
endpackage

// File: rtl/mcfg_wr_shape.sv
module mcfg_wr_shape
  import mcfg_pkg::*;
#(
  parameter int          VARIANT    = 1,
  parameter logic [31:0] CONF_FIXED = 32'h0
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] shaped_o
);
  always_comb begin
    shaped_o = wdata_i;
    unique case (32'(idx_i))
      IDX_GUARD: shaped_o = {31'b0, wdata_i == UNLOCK_KEY};
      IDX_CONF:  shaped_o = (wdata_i & ~CONF_RO_MASK) | CONF_FIXED;
      IDX_PHY: begin
        shaped_o[PHY_BUSY_BIT] = 1'b0;
        if (VARIANT != 0) shaped_o[PLL_LOCK_BIT] = 1'b1;
      end
      IDX_SELFTEST: begin
        shaped_o[ST_DONE_BIT] = 1'b1;
        shaped_o[ST_FAIL_BIT] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcfg_reg_array.sv
module mcfg_reg_array
  import mcfg_pkg::*;
#(
  parameter int          NUM_WORDS  = 64,
  parameter logic [31:0] CONF_FIXED = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lock_o
);
  localparam int SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    localparam logic [DATA_W-1:0] RST_VAL = (g == IDX_CONF) ? CONF_FIXED : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         words[g] <= RST_VAL;
      else if (we_i && 32'(widx_i) == g)   words[g] <= wdata_i;
    end
  end

  logic rd_in_range;
  assign rd_in_range = 32'(ridx_i) < NUM_WORDS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_in_range ? words[ridx_i[SEL_W-1:0]] : '0;
  end

  assign lock_o = words[IDX_GUARD][0];
endmodule

// File: rtl/mcfg_regbank.sv
module mcfg_regbank
  import mcfg_pkg::*;
#(
  parameter int NUM_WORDS   = 64,
  parameter int VARIANT     = 1,
  parameter int MIN_SIZE_MB = 256,
  parameter int MEM_SIZE_MB = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [31:0] CONF_FIXED = conf_fixed(VARIANT, MEM_SIZE_MB, MIN_SIZE_MB);

  if (!size_ok(MEM_SIZE_MB, MIN_SIZE_MB)) begin : g_bad_size
    $error("MEM_SIZE_MB must be MIN_SIZE_MB times 1, 2, 4 or 8");
  end
  if (NUM_WORDS <= IDX_SELFTEST || NUM_WORDS > (1 << IDX_W)) begin : g_bad_words
    $error("NUM_WORDS out of range");
  end

  logic              lock;
  logic              wr_in_range;
  logic              wr_commit;
  logic              rd_req;
  logic [DATA_W-1:0] shaped;

  assign wr_in_range = 32'(waddr_i) < NUM_WORDS;
  // guard word is always writable; everything else needs the key
  assign wr_commit   = req_i && we_i && wr_in_range &&
                       (32'(waddr_i) == IDX_GUARD || lock);
  assign rd_req      = req_i && !we_i;

  mcfg_wr_shape #(
    .VARIANT   (VARIANT),
    .CONF_FIXED(CONF_FIXED)
  ) shape_i (
    .idx_i   (waddr_i),
    .wdata_i (wdata_i),
    .shaped_o(shaped)
  );

  mcfg_reg_array #(
    .NUM_WORDS (NUM_WORDS),
    .CONF_FIXED(CONF_FIXED)
  ) array_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_commit),
    .widx_i (waddr_i),
    .wdata_i(shaped),
    .re_i   (rd_req),
    .ridx_i (waddr_i),
    .rdata_o(rdata_o),
    .lock_o (lock)
  );
endmodule

// File: rtl/mcfg_regbank_chk.sv
module mcfg_regbank_chk
  import mcfg_pkg::*;
#(
  parameter int          NUM_WORDS  = 64,
  parameter logic [31:0] CONF_FIXED = 32'h0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [IDX_W-1:0]  waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              lock,
  input logic              wr_commit
);
  logic rd;
  assign rd = req_i && !we_i;

  assert_guard_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && 32'(waddr_i) == IDX_GUARD |=> rdata_o[31:1] == '0);

  assert_key_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && 32'(waddr_i) == IDX_GUARD && wdata_i == UNLOCK_KEY |=> lock);

  assert_key_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && 32'(waddr_i) == IDX_GUARD && wdata_i != UNLOCK_KEY |=> !lock);

  assert_locked_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit && 32'(waddr_i) != IDX_GUARD |-> lock);

  assert_oob_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && 32'(waddr_i) >= NUM_WORDS |=> rdata_o == '0);

  assert_oob_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && 32'(waddr_i) >= NUM_WORDS |-> !wr_commit);

  assert_conf_ro_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && 32'(waddr_i) == IDX_CONF |=> (rdata_o & CONF_RO_MASK) == CONF_FIXED);

  assert_phy_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && 32'(waddr_i) == IDX_PHY |=> !rdata_o[PHY_BUSY_BIT]);

  assert_selftest_fail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && 32'(waddr_i) == IDX_SELFTEST |=> !rdata_o[ST_FAIL_BIT]);

  assert_rdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

bind mcfg_regbank mcfg_regbank_chk #(
  .NUM_WORDS (NUM_WORDS),
  .CONF_FIXED(CONF_FIXED)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .waddr_i  (waddr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .lock     (lock),
  .wr_commit(wr_commit)
);

// File: tb/mcfg_regbank_tb_top.sv
module mcfg_regbank_tb_top;
  localparam int          NW      = 64;
  localparam int          SPAN    = 1024;
  localparam logic [31:0] KEY     = 32'hFC60_0309;
  // VARIANT=1, size ratio 1024/256 = 4 -> code 2
  localparam logic [31:0] FIXED   = (32'd3 << 28) | (32'd3 << 2) | 32'd2;
  localparam logic [31:0] RO      = 32'hF00F_C04F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] model [SPAN];

  always #5 clk = ~clk;

  mcfg_regbank #(
    .NUM_WORDS(NW), .VARIANT(1), .MIN_SIZE_MB(256), .MEM_SIZE_MB(1024)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .waddr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  function automatic logic [31:0] shape(int idx, logic [31:0] d);
    logic [31:0] r = d;
    if (idx == 0) r = {31'b0, d == KEY};
    else if (idx == 1) r = (d & ~RO) | FIXED;
    else if (idx == 24) begin r[0] = 1'b0; r[4] = 1'b1; end
    else if (idx == 28) begin r[12] = 1'b1; r[13] = 1'b0; end
    return r;
  endfunction

  function automatic logic [31:0] pat(int i, logic [31:0] seed);
    return seed ^ (32'(i) * 32'h9E37_79B1);
  endfunction

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 10'(idx); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(int idx, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 10'(idx);
    @(negedge clk);
    req = 1'b0;
    vectors++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s idx=%0d actual=%h expected=%h", tag, idx, rdata, exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < SPAN; i++) rd_chk(i, model[i], tag);
  endtask

  task automatic model_write(int i, logic [31:0] d);
    if (i < NW && (i == 0 || model[0][0])) model[i] = shape(i, d);
  endtask

  initial begin
    for (int i = 0; i < SPAN; i++) model[i] = '0;
    model[1] = FIXED;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R5 out-of-range reads
    sweep("R1_R5_reset");

    // R3 locked writes dropped everywhere (R5 beyond NW)
    for (int i = 1; i < SPAN; i++) begin
      wr(i, pat(i, 32'hDEAD_0000));
      model_write(i, pat(i, 32'hDEAD_0000));
    end
    sweep("R3_locked");

    // R2 near-miss keys leave the bank locked
    wr(0, KEY ^ 32'h1);         model_write(0, KEY ^ 32'h1);
    rd_chk(0, 32'h0, "R2_nearkey");
    wr(0, KEY ^ 32'h8000_0000); model_write(0, KEY ^ 32'h8000_0000);
    rd_chk(0, 32'h0, "R2_nearkey");
    wr(0, KEY);                 model_write(0, KEY);
    rd_chk(0, 32'h1, "R2_unlock");

    // R6 R7 R8 R9 R10 R4 R5: unlocked full sweep, two patterns
    for (int i = 1; i < SPAN; i++) begin
      wr(i, pat(i, 32'hA5C3_5A3C)); model_write(i, pat(i, 32'hA5C3_5A3C));
    end
    sweep("R6_R8_R9_R10_unlocked_a");
    for (int i = 1; i < SPAN; i++) begin
      wr(i, ~pat(i, 32'h0F0F_F0F0)); model_write(i, ~pat(i, 32'h0F0F_F0F0));
    end
    sweep("R6_R8_R9_R10_unlocked_b");

    // R6 R7 extremes on the configuration word
    wr(1, 32'hFFFF_FFFF); model_write(1, 32'hFFFF_FFFF);
    rd_chk(1, 32'h3FF0_3FBE, "R6_R7_conf_ones");
    wr(1, 32'h0);         model_write(1, 32'h0);
    rd_chk(1, FIXED, "R6_R7_conf_zero");
    // R8 R9 extremes
    wr(24, 32'hFFFF_FFFF); model_write(24, 32'hFFFF_FFFF);
    rd_chk(24, 32'hFFFF_FFFE, "R8_phy_ones");
    wr(24, 32'h0);         model_write(24, 32'h0);
    rd_chk(24, 32'h0000_0010, "R8_phy_zero");
    wr(28, 32'hFFFF_FFFF); model_write(28, 32'hFFFF_FFFF);
    rd_chk(28, 32'hFFFF_DFFF, "R9_selftest_ones");
    wr(28, 32'h0);         model_write(28, 32'h0);
    rd_chk(28, 32'h0000_1000, "R9_selftest_zero");

    // R2 relock with a wrong value, then R3 writes dropped again
    wr(0, 32'h0); model_write(0, 32'h0);
    rd_chk(0, 32'h0, "R2_relock");
    for (int i = 1; i < NW; i++) begin
      wr(i, 32'h1234_5678); model_write(i, 32'h1234_5678);
    end
    sweep("R3_relocked");

    // R4 read data holds without a new read strobe
    rd_chk(1, model[1], "R4_hold");
    repeat (4) @(negedge clk);
    vectors++;
    if (rdata !== model[1]) begin
      fails++;
      $display("FAIL R4_hold actual=%h expected=%h", rdata, model[1]);
    end

    // R1 reset again after activity
    wr(0, KEY);
    wr(5, 32'hFFFF_FFFF);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < SPAN; i++) model[i] = '0;
    model[1] = FIXED;
    sweep("R1_rereset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule